// File: doc/BRIEF.md
# Drive Command Handshake Controller

This controller sits between a host command port and the units that carry out drive actions, such as positioning and spindle sequencing. After reset it waits for a command strobe. It captures the opcode and argument and decodes the opcode. For an action command it fires a one-cycle start pulse toward the matching unit and waits for that unit's done response. When the command finishes, it posts an 8-bit status word. It then holds that word until the host acknowledges it, and only after the acknowledge does it return to idle.

The status side works as a valid/ready pair. `status_valid` stays high and `status_word` stays frozen for as long as `status_ack` is low, so the host can apply back-pressure for any number of cycles. The command side uses a plain strobe with no buffering. `busy` tells the host when a strobe will be taken. A strobe that arrives while `busy` is high is dropped, and the controller records that in the next status word.

Opcodes 0 to 7 select, in order: spin-up sequence, spin-down sequence, seek, rezero, head advance, set sector, diagnostic and status query. Opcodes 8 to 15 are illegal.

Top module: `drv_cmd_ctrl`

## Requirements
- R1: After reset, `busy`, `status_valid` and `act_start` are low and `status_word` is zero.
- R2: In idle, a high `cmd_stb` is accepted at the next clock edge. From that edge `busy` is high, and `act_arg` carries the captured argument.
- R3: For an accepted opcode k in the range 0 to 6, exactly one bit of `act_start` (bit k) is high, for exactly one cycle, starting at the second clock edge after the accepting edge.
- R4: Opcode 7 (status query) fires no start pulse. It posts status at the second edge after acceptance, with the done bit set.
- R5: Opcodes 8 to 15 fire no start pulse. They post status at the second edge after acceptance, with the illegal bit (bit 6) set and the done bit clear.
- R6: While an action runs, `exec_done` posts status at the next edge. The word then has the opcode in bits 3:0, done in bit 4, and in bit 5 the value of `exec_err` sampled together with `exec_done`.
- R7: While `status_valid` is high and `status_ack` is low, `status_valid` stays high and `status_word` does not change. An acknowledge returns the controller to idle at the next edge.
- R8: A strobe seen while `busy` is high causes no start pulse and does not alter the command in progress. It sets the overrun bit (bit 7) in the next posted word, and that bit is clear again in the word after.
- R9: `exec_done` is ignored when no action is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_stb | input | 1 | Command strobe |
| cmd_opc | input | 4 | Command opcode |
| cmd_arg | input | ARG_W | Command argument |
| exec_done | input | 1 | Action unit finished |
| exec_err | input | 1 | Action unit error, sampled with exec_done |
| status_ack | input | 1 | Host accepts the status word |
| act_start | output | 7 | One-hot start pulses, bit k for opcode k |
| act_arg | output | ARG_W | Argument of the current command |
| status_word | output | 8 | {overrun, illegal, error, done, opcode} |
| status_valid | output | 1 | Status word posted and awaiting ack |
| busy | output | 1 | Controller not idle |

## Verification
The assertions check the following on every cycle: start pulses are one-hot and last a single cycle, a posted word stays frozen while the host stalls, every acknowledge leads back to idle, and the illegal and done bits never appear together. Other behaviours depend on a particular command sequence, and only the bench scenarios can show them. These are the opcode-to-pulse mapping, the exact posting latency for each command class, error capture, and overrun being carried into the next word and then cleared. The same applies to stray done pulses, which must have no effect.

// File: rtl/drv_cmd_pkg.sv
package drv_cmd_pkg;
  localparam int OPC_W    = 4;
  localparam int N_ACT    = 7;
  localparam int STAT_OPC = 7;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DECODE = 2'd1,
    ST_EXEC   = 2'd2,
    ST_POST   = 2'd3
  } ctl_state_e;

  typedef struct packed {
    logic             ovr;
    logic             illegal;
    logic             err;
    logic             done;
    logic [OPC_W-1:0] opc;
  } status_t;

  localparam int STAT_W = $bits(status_t);
endpackage

// File: rtl/drv_cmd_decode.sv
module drv_cmd_decode
  import drv_cmd_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  output logic [N_ACT-1:0] act_onehot,
  output logic             is_act,
  output logic             is_stat,
  output logic             is_bad
);
  // one comparator per action opcode
  for (genvar i = 0; i < N_ACT; i++) begin : g_act
    assign act_onehot[i] = (opc == OPC_W'(i));
  end

  always_comb begin
    is_act  = |act_onehot;
    is_stat = (opc == OPC_W'(STAT_OPC));
    is_bad  = !is_act && !is_stat;
  end
endmodule

// File: rtl/drv_cmd_fsm.sv
module drv_cmd_fsm
  import drv_cmd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_stb,
  input  logic exec_done,
  input  logic status_ack,
  input  logic dec_act,
  output logic latch_cmd,
  output logic fire,
  output logic post_load,
  output logic in_exec,
  output logic stray_stb,
  output logic busy,
  output logic status_valid
);
  ctl_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (cmd_stb) state_d = ST_DECODE;
      ST_DECODE: state_d = dec_act ? ST_EXEC : ST_POST;
      ST_EXEC:   if (exec_done) state_d = ST_POST;
      ST_POST:   if (status_ack) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    busy         = (state_q != ST_IDLE);
    status_valid = (state_q == ST_POST);
    in_exec      = (state_q == ST_EXEC);
    latch_cmd    = (state_q == ST_IDLE) && cmd_stb;
    fire         = (state_q == ST_DECODE) && dec_act;
    post_load    = ((state_q == ST_DECODE) && !dec_act) || (in_exec && exec_done);
    stray_stb    = busy && cmd_stb;
  end
endmodule

// File: rtl/drv_status_reg.sv
module drv_status_reg
  import drv_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             post_load,
  input  logic             in_exec,
  input  logic             exec_err,
  input  logic             is_bad,
  input  logic             stray_stb,
  input  logic [OPC_W-1:0] opc,
  output status_t          word
);
  logic ovr_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word     <= '0;
      ovr_pend <= 1'b0;
    end else if (post_load) begin
      word.opc     <= opc;
      word.done    <= !is_bad;
      word.err     <= in_exec && exec_err;
      word.illegal <= is_bad;
      word.ovr     <= ovr_pend || stray_stb;
      ovr_pend     <= 1'b0;
    end else if (stray_stb) begin
      ovr_pend <= 1'b1;
    end
  end
endmodule

// File: rtl/drv_cmd_ctrl.sv
module drv_cmd_ctrl
  import drv_cmd_pkg::*;
#(
  parameter int ARG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_stb,
  input  logic [3:0]       cmd_opc,
  input  logic [ARG_W-1:0] cmd_arg,
  input  logic             exec_done,
  input  logic             exec_err,
  input  logic             status_ack,
  output logic [6:0]       act_start,
  output logic [ARG_W-1:0] act_arg,
  output logic [7:0]       status_word,
  output logic             status_valid,
  output logic             busy
);
  logic [OPC_W-1:0] opc_q;
  logic [N_ACT-1:0] act_onehot, start_q;
  logic is_act, is_stat, is_bad;
  logic latch_cmd, fire, post_load, in_exec, stray_stb;
  status_t word;

  drv_cmd_decode u_dec (
    .opc(opc_q), .act_onehot(act_onehot),
    .is_act(is_act), .is_stat(is_stat), .is_bad(is_bad)
  );

  drv_cmd_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .exec_done(exec_done),
    .status_ack(status_ack), .dec_act(is_act), .latch_cmd(latch_cmd),
    .fire(fire), .post_load(post_load), .in_exec(in_exec),
    .stray_stb(stray_stb), .busy(busy), .status_valid(status_valid)
  );

  drv_status_reg u_stat (
    .clk(clk), .rst_n(rst_n), .post_load(post_load), .in_exec(in_exec),
    .exec_err(exec_err), .is_bad(is_bad), .stray_stb(stray_stb),
    .opc(opc_q), .word(word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opc_q   <= '0;
      act_arg <= '0;
      start_q <= '0;
    end else begin
      if (latch_cmd) begin
        opc_q   <= cmd_opc;
        act_arg <= cmd_arg;
      end
      start_q <= fire ? act_onehot : '0;
    end
  end

  logic unused_stat;
  assign unused_stat = is_stat;
  assign act_start   = start_q;
  assign status_word = word;
endmodule

// File: rtl/drv_cmd_ctrl_chk.sv
module drv_cmd_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [6:0] act_start,
  input logic [7:0] status_word,
  input logic       status_valid,
  input logic       status_ack,
  input logic       busy
);
  assert_start_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act_start));
  assert_start_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (act_start != 0) |=> (act_start == 0));
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (act_start != 0) |-> busy);
  assert_post_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_valid && !status_ack) |=> (status_valid && $stable(status_word)));
  assert_ack_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_valid && status_ack) |=> !busy);
  assert_valid_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    status_valid |-> busy);
  assert_bad_not_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    status_valid |-> !(status_word[6] && status_word[4]));
endmodule

bind drv_cmd_ctrl drv_cmd_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .act_start(act_start), .status_word(status_word),
  .status_valid(status_valid), .status_ack(status_ack), .busy(busy)
);

// File: tb/sim_drv_cmd_ctrl.sv
module sim_drv_cmd_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ARG_W = 16;
  // {opcode[3:0], exec_err, expected status word[7:0]}
  localparam logic [12:0] VEC [10] = '{
    {4'd0, 1'b0, 8'h10}, {4'd1, 1'b1, 8'h31}, {4'd2, 1'b0, 8'h12},
    {4'd3, 1'b1, 8'h33}, {4'd4, 1'b0, 8'h14}, {4'd5, 1'b0, 8'h15},
    {4'd6, 1'b1, 8'h36}, {4'd7, 1'b1, 8'h17}, {4'd9, 1'b0, 8'h49},
    {4'd15, 1'b1, 8'h4F}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_stb = 1'b0, exec_done = 1'b0, exec_err = 1'b0, status_ack = 1'b0;
  logic [3:0] cmd_opc = '0;
  logic [ARG_W-1:0] cmd_arg = '0;
  logic [6:0] act_start;
  logic [ARG_W-1:0] act_arg;
  logic [7:0] status_word;
  logic status_valid, busy;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  drv_cmd_ctrl #(.ARG_W(ARG_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_opc(cmd_opc),
    .cmd_arg(cmd_arg), .exec_done(exec_done), .exec_err(exec_err),
    .status_ack(status_ack), .act_start(act_start), .act_arg(act_arg),
    .status_word(status_word), .status_valid(status_valid), .busy(busy)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic nstep();
    @(negedge clk);
  endtask

  task automatic strobe(input logic [3:0] op, input logic [ARG_W-1:0] arg);
    cmd_stb = 1'b1; cmd_opc = op; cmd_arg = arg;
    nstep();
    cmd_stb = 1'b0;
  endtask

  task automatic ack();
    status_ack = 1'b1;
    nstep();
    status_ack = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    nstep(); nstep();
    // R1 reset state
    check("R1 busy", {31'd0, busy}, 0);
    check("R1 valid", {31'd0, status_valid}, 0);
    check("R1 start", {25'd0, act_start}, 0);
    check("R1 word", {24'd0, status_word}, 0);
    rst_n = 1'b1;
    nstep();

    for (int i = 0; i < 10; i++) begin
      logic [3:0] op;
      logic er;
      logic [7:0] ew;
      {op, er, ew} = VEC[i];
      strobe(op, ARG_W'(16'h100 + i));
      check("R2 busy", {31'd0, busy}, 1);
      check("R2 arg", {16'd0, act_arg}, 32'h100 + i);
      nstep();
      if (op < 7) begin
        check("R3 pulse", {25'd0, act_start}, 32'd1 << op);
        check("R6 not yet", {31'd0, status_valid}, 0);
        exec_done = 1'b1; exec_err = er;
        nstep();
        exec_done = 1'b0; exec_err = 1'b0;
        check("R3 one cycle", {25'd0, act_start}, 0);
        check("R6 word", {24'd0, status_word}, {24'd0, ew});
      end else begin
        check(op == 7 ? "R4 no pulse" : "R5 no pulse", {25'd0, act_start}, 0);
        check(op == 7 ? "R4 word" : "R5 word", {24'd0, status_word}, {24'd0, ew});
      end
      check("R7 valid", {31'd0, status_valid}, 1);
      ack();
      check("R7 idle", {31'd0, busy}, 0);
      check("R7 valid low", {31'd0, status_valid}, 0);
    end

    // R9: stray done while idle
    exec_done = 1'b1; exec_err = 1'b1;
    nstep();
    exec_done = 1'b0; exec_err = 1'b0;
    nstep();
    check("R9 valid", {31'd0, status_valid}, 0);
    check("R9 busy", {31'd0, busy}, 0);
    check("R9 word", {24'd0, status_word}, 32'h4F);

    // R8: strobe during exec, then during post
    strobe(4'd2, 16'hBEEF);
    nstep();
    check("R3 seek pulse", {25'd0, act_start}, 32'h04);
    strobe(4'd3, 16'h1234);
    check("R8 no pulse", {25'd0, act_start}, 0);
    check("R8 arg kept", {16'd0, act_arg}, 32'hBEEF);
    check("R8 still exec", {31'd0, status_valid}, 0);
    exec_done = 1'b1;
    nstep();
    exec_done = 1'b0;
    check("R8 overrun word", {24'd0, status_word}, 32'h92);
    // R7: host stalls
    nstep(); nstep(); nstep();
    check("R7 stall valid", {31'd0, status_valid}, 1);
    check("R7 stall word", {24'd0, status_word}, 32'h92);
    strobe(4'd0, 16'h0);
    check("R8 no pulse in post", {25'd0, act_start}, 0);
    ack();
    strobe(4'd7, 16'h0);
    nstep();
    check("R8 next word overrun", {24'd0, status_word}, 32'h97);
    ack();
    strobe(4'd7, 16'h0);
    nstep();
    check("R8 overrun cleared", {24'd0, status_word}, 32'h17);
    ack();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule